// File: doc/BRIEF.md
# Masked Pattern Detector with Overflow and Auto-Reset

This block watches the value an accumulator is about to capture and, in step with that capture, reports whether the value agrees with a programmable pattern. A mask selects which bit positions take part in the comparison. A second flag reports agreement with the bitwise inverse of the pattern. The block keeps the previous cycle's two agreement flags, and from them it reports that an accumulator has wrapped out of the pattern region (overflow) or out of the inverted-pattern region (underflow). It can also raise a reset request for the accumulator when the value reaches a terminal count.

The usual configuration sets the pattern to a boundary value such as zero, or a saturation threshold. The upper bits of the mask are cleared so that only the sign-extension region is compared. The accumulator's next-state value is fed to `val_i`, and the flags appear on the same edge at which the accumulator register loads that value. A build parameter chooses whether the reset request follows the pattern flag or the inverted-pattern flag.

Top module: `mpd_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: One cycle after a value is presented, `match_o` is 1 exactly when every bit position whose `mask_i` bit is 0 holds the same bit in `val_i` as in `pat_i`. Positions whose mask bit is 1 are ignored.
- R3: One cycle after a value is presented, `cmatch_o` is 1 exactly when every bit position whose mask bit is 0 holds in `val_i` the inverse of the `pat_i` bit.
- R4: `ovf_o` rises one cycle after a value that matches neither the pattern nor its inverse, when `match_o` was 1 during the cycle that value was presented. It is otherwise 0, so it lasts a single cycle.
- R5: `unf_o` follows the rule of R4 with `cmatch_o` in place of `match_o`.
- R6: With the mask all ones, both agreement flags are 1. A following value that agrees with neither then raises `ovf_o` and `unf_o` in the same cycle.
- R7: With the default trigger choice (pattern), `acc_rst_o` is 1 one cycle after a value that matches the pattern was presented with `ar_en_i` = 1. With `ar_en_i` = 0 it stays 0 whatever the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| val_i | input | 48 | Accumulator next-state value under test |
| pat_i | input | 48 | Pattern to compare against |
| mask_i | input | 48 | Per-bit ignore mask (1 = ignore) |
| ar_en_i | input | 1 | Enables the accumulator reset request |
| match_o | output | 1 | Registered pattern agreement |
| cmatch_o | output | 1 | Registered inverted-pattern agreement |
| ovf_o | output | 1 | One-cycle overflow indication |
| unf_o | output | 1 | One-cycle underflow indication |
| acc_rst_o | output | 1 | Reset request for the accumulator |

## Verification
Overflow and underflow can fall in the same cycle. This happens only when the previous value agreed with both the pattern and its inverse, which requires a fully ignoring mask. The bench provokes it with an all-ones mask followed by a value that disagrees in unmasked bits with both forms. It then expects both indications together, and expects both to be clear the next cycle. Random stimulus also builds values from the pattern or its inverse with bits flipped only under the mask, so that agreement, wrap-out and reset-request cycles occur often. Every output is judged against a bench model that holds its own copy of the previous agreement flags.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    localparam int DATA_W_DEF = 48;
    localparam int LANE_W_DEF = 12;

    typedef enum logic {
        TRIG_PATTERN    = 1'b0,
        TRIG_COMPLEMENT = 1'b1
    } trig_e;

    typedef struct packed {
        logic hit;
        logic chit;
    } agree_t;

    typedef struct packed {
        logic match;
        logic cmatch;
        logic ovf;
        logic unf;
        logic arst;
    } flags_t;

    function automatic logic wrap_out(input logic prev_side, input agree_t now);
        return prev_side & ~now.hit & ~now.chit;
    endfunction

endpackage

// File: rtl/mpd_lane_cmp.sv
module mpd_lane_cmp
    import mpd_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] mask_i,
    output agree_t            agree_o
);
    localparam int NLANE = (DATA_W + LANE_W - 1) / LANE_W;

    logic [DATA_W-1:0] ok_p;
    logic [DATA_W-1:0] ok_c;
    logic [NLANE-1:0]  lane_p;
    logic [NLANE-1:0]  lane_c;

    always_comb begin
        ok_p = ~(val_i ^ pat_i) | mask_i;
        ok_c = (val_i ^ pat_i) | mask_i;
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int LO = l * LANE_W;
        localparam int HI = ((l + 1) * LANE_W > DATA_W) ? DATA_W - 1 : (l + 1) * LANE_W - 1;
        assign lane_p[l] = &ok_p[HI:LO];
        assign lane_c[l] = &ok_c[HI:LO];
    end

    always_comb begin
        agree_o.hit  = &lane_p;
        agree_o.chit = &lane_c;
    end
endmodule

// File: rtl/mpd_history.sv
module mpd_history
    import mpd_pkg::*;
(
    input  logic   prev_match_i,
    input  logic   prev_cmatch_i,
    input  agree_t now_i,
    output logic   ovf_next_o,
    output logic   unf_next_o
);
    always_comb begin
        ovf_next_o = wrap_out(prev_match_i, now_i);
        unf_next_o = wrap_out(prev_cmatch_i, now_i);
    end
endmodule

// File: rtl/mpd_autorst.sv
module mpd_autorst
    import mpd_pkg::*;
#(
    parameter trig_e TRIG = TRIG_PATTERN
) (
    input  logic   en_i,
    input  agree_t now_i,
    output logic   req_next_o
);
    if (TRIG == TRIG_COMPLEMENT) begin : g_cmp
        assign req_next_o = en_i & now_i.chit;
    end else begin : g_pat
        assign req_next_o = en_i & now_i.hit;
    end
endmodule

// File: rtl/mpd_detect.sv
module mpd_detect
    import mpd_pkg::*;
#(
    parameter int    DATA_W = DATA_W_DEF,
    parameter int    LANE_W = LANE_W_DEF,
    parameter trig_e TRIG   = TRIG_PATTERN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] val_i,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              ar_en_i,
    output logic              match_o,
    output logic              cmatch_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              acc_rst_o
);
    agree_t now;
    logic   ovf_next;
    logic   unf_next;
    logic   req_next;
    flags_t flags_q;

    mpd_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .val_i  (val_i),
        .pat_i  (pat_i),
        .mask_i (mask_i),
        .agree_o(now)
    );

    mpd_history u_hist (
        .prev_match_i (flags_q.match),
        .prev_cmatch_i(flags_q.cmatch),
        .now_i        (now),
        .ovf_next_o   (ovf_next),
        .unf_next_o   (unf_next)
    );

    mpd_autorst #(.TRIG(TRIG)) u_ar (
        .en_i      (ar_en_i),
        .now_i     (now),
        .req_next_o(req_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.match  <= now.hit;
            flags_q.cmatch <= now.chit;
            flags_q.ovf    <= ovf_next;
            flags_q.unf    <= unf_next;
            flags_q.arst   <= req_next;
        end
    end

    assign match_o   = flags_q.match;
    assign cmatch_o  = flags_q.cmatch;
    assign ovf_o     = flags_q.ovf;
    assign unf_o     = flags_q.unf;
    assign acc_rst_o = flags_q.arst;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker
    import mpd_pkg::*;
#(
    parameter trig_e TRIG = TRIG_PATTERN
) (
    input logic clk,
    input logic rst,
    input logic ar_en_i,
    input logic match_o,
    input logic cmatch_o,
    input logic ovf_o,
    input logic unf_o,
    input logic acc_rst_o
);
    // R4: overflow only after a cycle of pattern agreement
    a_r4_ovf_after_match: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(match_o));

    // R4: overflow never lasts two cycles
    a_r4_ovf_single: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o);

    // R4: overflow excludes any agreement in the same cycle
    a_r4_ovf_no_agree: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !(match_o || cmatch_o));

    // R5: underflow only after a cycle of inverse agreement
    a_r5_unf_after_cmatch: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> $past(cmatch_o));

    // R5: underflow never lasts two cycles
    a_r5_unf_single: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> !unf_o);

    // R7: request needs the enable in the previous cycle
    a_r7_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        acc_rst_o |-> $past(ar_en_i));

    // R7: request accompanies the selected agreement flag
    a_r7_req_with_flag: assert property (@(posedge clk) disable iff (rst)
        acc_rst_o |-> ((TRIG == TRIG_COMPLEMENT) ? cmatch_o : match_o));
endmodule

bind mpd_detect mpd_checker #(.TRIG(TRIG)) u_mpd_checker (
    .clk      (clk),
    .rst      (rst),
    .ar_en_i  (ar_en_i),
    .match_o  (match_o),
    .cmatch_o (cmatch_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o),
    .acc_rst_o(acc_rst_o)
);

// File: tb/test_mpd_detect.sv
module test_mpd_detect;
    localparam int W = 48;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] val_i = '0;
    logic [W-1:0] pat_i = '0;
    logic [W-1:0] mask_i = '0;
    logic         ar_en_i = 1'b0;
    logic         match_o, cmatch_o, ovf_o, unf_o, acc_rst_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    bit  pm = 0;
    bit  pcm = 0;

    always #4 clk = ~clk;

    mpd_detect i_mpd_detect (
        .clk(clk), .rst(rst), .val_i(val_i), .pat_i(pat_i), .mask_i(mask_i),
        .ar_en_i(ar_en_i), .match_o(match_o), .cmatch_o(cmatch_o),
        .ovf_o(ovf_o), .unf_o(unf_o), .acc_rst_o(acc_rst_o)
    );

    function automatic bit f_hit(logic [W-1:0] v, logic [W-1:0] p, logic [W-1:0] m);
        return ((v ^ p) & ~m) == '0;
    endfunction

    function automatic bit f_chit(logic [W-1:0] v, logic [W-1:0] p, logic [W-1:0] m);
        return ((v ^ ~p) & ~m) == '0;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] v, logic [W-1:0] p, logic [W-1:0] m, logic en);
        bit em, ecm, eo, eu, ea;
        @(negedge clk);
        val_i = v; pat_i = p; mask_i = m; ar_en_i = en;
        em  = f_hit(v, p, m);
        ecm = f_chit(v, p, m);
        eo  = pm  && !em && !ecm;
        eu  = pcm && !em && !ecm;
        ea  = en && em;
        @(posedge clk);
        #1;
        chk("R2", "match", match_o, em);
        chk("R3", "cmatch", cmatch_o, ecm);
        chk("R4", "ovf", ovf_o, eo);
        chk("R5", "unf", unf_o, eu);
        chk("R7", "acc_rst", acc_rst_o, ea);
        pm = em;
        pcm = ecm;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] p, m, v;
        int sd;
        sd = $urandom(32'h5eed_1234);
        // R1: reset state, with inputs that would otherwise match
        val_i = '0; pat_i = '0; mask_i = '0; ar_en_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "match", match_o, 1'b0);
        chk("R1", "cmatch", cmatch_o, 1'b0);
        chk("R1", "ovf", ovf_o, 1'b0);
        chk("R1", "unf", unf_o, 1'b0);
        chk("R1", "acc_rst", acc_rst_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        ar_en_i = 1'b0;

        // R2: exact match, then masked-bit difference still matches
        p = 48'h0000_0000_0000;
        m = 48'h0000_0000_0FFF;
        apply(48'h0, p, m, 1'b0);
        apply(48'h0000_0000_0ABC, p, m, 1'b0);
        // R4: leave pattern region -> overflow one cycle, then cleared
        apply(48'h0000_0001_0000, p, m, 1'b0);
        apply(48'h0000_0001_0000, p, m, 1'b0);
        // R3 then R5: inverse region, then leave -> underflow
        apply(48'hFFFF_FFFF_F123, p, m, 1'b0);
        apply(48'h0000_0F00_0000, p, m, 1'b0);
        // R7: terminal count with enable gives request; without enable none
        apply(48'h0000_0000_0001, p, m, 1'b1);
        apply(48'h0000_0000_0001, p, m, 1'b0);
        apply(48'h1234_0000_0000, p, m, 1'b1);
        // R6: fully masked, then a value agreeing with neither
        apply(48'h1234_5678_9ABC, p, '1, 1'b0);
        chk("R6", "both agree", match_o & cmatch_o, 1'b1);
        apply(48'h0000_FFFF_0000, p, '0, 1'b0);
        chk("R6", "both wrap", ovf_o & unf_o, 1'b1);
        apply(48'h0000_FFFF_0000, p, '0, 1'b0);

        // random mix: R2 R3 R4 R5 R7
        for (int i = 0; i < 3000; i++) begin
            int kind;
            p = {$urandom(), $urandom()};
            m = ($urandom_range(0, 3) == 0) ? '0 : ({$urandom(), $urandom()} & {$urandom(), $urandom()});
            kind = $urandom_range(0, 3);
            v = {$urandom(), $urandom()} & m;
            case (kind)
                0: v = v | (p & ~m);
                1: v = v | (~p & ~m);
                2: v = {$urandom(), $urandom()};
                default: v = (v | (p & ~m)) ^ (48'h1 << $urandom_range(0, W - 1));
            endcase
            apply(v, p, m, 1'($urandom_range(0, 1)));
        end

        // R1: reset mid-stream clears flags
        @(negedge clk);
        rst = 1'b1; val_i = '0; pat_i = '0; mask_i = '0; ar_en_i = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "match after reset", match_o, 1'b0);
        chk("R1", "acc_rst after reset", acc_rst_o, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule